// File: doc/BRIEF.md
# Programmable Microsecond Timebase and Gap Timer

This block turns the system clock of a serial bus controller into a microsecond timebase. A first prescale stage divides the system clock, whose frequency is one of four settings, into a one-microsecond pre-tick. A second stage divides that pre-tick by 1, 4, 8 or 32 to produce the rate tick. The rate tick drives a free-running CLOCK counter, and the surrounding sequencer uses the same tick for its TIMER.

The CLOCK counter advances only while counting is enabled. The enable comes from a level input, or from a sticky flag that is set when the sequencer executes its wait-on-clock instruction. A controller start strobe can zero the counter when the auto-clear option is selected.

A separate gap timer measures the minimum idle time between messages. The sequencer pulses a request, and the timer returns a one-cycle done pulse after 4, 8, 16 or 32 microseconds. The gap timer always counts the one-microsecond pre-tick, so the rate setting has no effect on it.

Top module: `usec_timebase`

## Requirements
- R1: With rate_sel = 00, rate_tick pulses every 12, 16, 20 or 24 system clocks for freq_sel = 00, 01, 10 or 11 (12, 16, 20 or 24 MHz).
- R2: rate_sel = 00, 01, 10 or 11 multiplies the rate_tick period by 1, 4, 8 or 32 one-microsecond pre-ticks.
- R3: rate_tick is high for exactly one clock per period.
- R4: In the clock after rate_tick is high, clock_val rises by one if counting is enabled (count_en high or the wait flag set). Otherwise clock_val holds.
- R5: A one-clock pulse on wait_exec sets a wait flag that keeps counting enabled with count_en low, until reset.
- R6: start with auto_clr = 1 makes clock_val 0 in the next clock, and this wins over an increment. start with auto_clr = 0 leaves counting unaffected.
- R7: clock_val wraps from all ones to zero and continues counting.
- R8: After a gap_req pulse, gap_done is high for one clock once 4, 8, 16 or 32 pre-ticks (gap_sel = 00, 01, 10, 11) have occurred after the request. gap_done coincides with the rate_tick of the last of those pre-ticks when rate_sel = 00. A new request restarts the count.
- R9: After reset, clock_val is 0, rate_tick and gap_done are low, and the wait flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | System clock frequency code |
| rate_sel | input | 2 | Rate tick period code |
| count_en | input | 1 | Counting enable level |
| wait_exec | input | 1 | Wait-on-clock instruction executed (pulse) |
| start | input | 1 | Controller start strobe |
| auto_clr | input | 1 | Clear CLOCK on start when high |
| gap_req | input | 1 | Start an inter-message gap (pulse) |
| gap_sel | input | 2 | Gap length code |
| clock_val | output | CLK_W (16) | Free-running CLOCK value |
| rate_tick | output | 1 | One-clock rate tick |
| gap_done | output | 1 | One-clock gap-elapsed pulse |

## Verification
The bench measures tick spacing for every frequency code and every rate code. A wrong reload value or a wrong divider length shows up as a period that is off by whole clocks or whole microseconds.

The gap length is checked in exact pre-ticks, both for the plain case and for a restarted request. A design that counted the request-cycle tick, or that ignored the restart, would finish one microsecond early or would finish on the stale request.

The bench also covers these corner cases:
- Clear against a coincident increment.
- The sticky wait flag with the level enable low.
- Wrap-around on a narrow instance.

A design that gave priority to the increment, dropped the flag, or saturated the counter would each end at a value that differs from the model.

// File: rtl/utb_pkg.sv
package utb_pkg;
  // Reload value of the microsecond prescaler for a frequency code.
  function automatic int unsigned pre_reload(input logic [1:0] sel,
                                             input int unsigned base,
                                             input int unsigned step);
    return base - 1 + step * int'(sel);
  endfunction

  // Number of microsecond pre-ticks per rate tick.
  function automatic int unsigned rate_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 32;
    endcase
  endfunction

  // Gap length in microseconds.
  function automatic int unsigned gap_len(input logic [1:0] sel,
                                          input int unsigned base);
    return base << sel;
  endfunction
endpackage

// File: rtl/utb_prescaler.sv
module utb_prescaler #(
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned STEP_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] freq_sel,
  output logic       pre_tick
);
  import utb_pkg::*;
  localparam int unsigned PW = $clog2(BASE_DIV + 3 * STEP_DIV);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] reload;

  assign reload = PW'(pre_reload(freq_sel, BASE_DIV, STEP_DIV));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      pre_tick <= 1'b0;
    end else if (cnt_q >= reload) begin
      cnt_q    <= '0;
      pre_tick <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      pre_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/utb_rate_div.sv
module utb_rate_div #(
  parameter int unsigned MAX_RATE = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       pre_tick,
  output logic       rate_tick
);
  import utb_pkg::*;
  localparam int unsigned RW = $clog2(MAX_RATE);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] last;

  assign last = RW'(rate_len(rate_sel) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rate_tick <= 1'b0;
    end else begin
      rate_tick <= 1'b0;
      if (pre_tick) begin
        if (cnt_q >= last) begin
          cnt_q     <= '0;
          rate_tick <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/utb_clock_ctr.sv
module utb_clock_ctr #(
  parameter int unsigned CLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_tick,
  input  logic             count_en,
  input  logic             wait_exec,
  input  logic             start,
  input  logic             auto_clr,
  output logic [CLK_W-1:0] clock_val,
  output logic             en_eff
);
  logic wait_seen_q;

  assign en_eff = count_en | wait_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clock_val   <= '0;
      wait_seen_q <= 1'b0;
    end else begin
      if (wait_exec) wait_seen_q <= 1'b1;
      if (start && auto_clr)       clock_val <= '0;
      else if (rate_tick && en_eff) clock_val <= clock_val + 1'b1;
    end
  end
endmodule

// File: rtl/utb_gap_timer.sv
module utb_gap_timer #(
  parameter int unsigned GAP_BASE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gap_req,
  input  logic [1:0] gap_sel,
  input  logic       pre_tick,
  output logic       gap_done,
  output logic       gap_busy
);
  import utb_pkg::*;
  localparam int unsigned GW = $clog2(GAP_BASE * 8 + 1);

  logic [GW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      gap_busy <= 1'b0;
      gap_done <= 1'b0;
    end else begin
      gap_done <= 1'b0;
      if (gap_req) begin
        left_q   <= GW'(gap_len(gap_sel, GAP_BASE));
        gap_busy <= 1'b1;
      end else if (gap_busy && pre_tick) begin
        if (left_q == GW'(1)) begin
          gap_busy <= 1'b0;
          gap_done <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int unsigned CLK_W    = 16,
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned STEP_DIV = 4,
  parameter int unsigned MAX_RATE = 32,
  parameter int unsigned GAP_BASE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       freq_sel,
  input  logic [1:0]       rate_sel,
  input  logic             count_en,
  input  logic             wait_exec,
  input  logic             start,
  input  logic             auto_clr,
  input  logic             gap_req,
  input  logic [1:0]       gap_sel,
  output logic [CLK_W-1:0] clock_val,
  output logic             rate_tick,
  output logic             gap_done
);
  logic pre_tick;
  logic en_eff;
  logic gap_busy;

  utb_prescaler #(.BASE_DIV(BASE_DIV), .STEP_DIV(STEP_DIV)) u_pre (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .pre_tick(pre_tick));

  utb_rate_div #(.MAX_RATE(MAX_RATE)) u_rate (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .pre_tick(pre_tick),
    .rate_tick(rate_tick));

  utb_clock_ctr #(.CLK_W(CLK_W)) u_clk (
    .clk(clk), .rst(rst), .rate_tick(rate_tick), .count_en(count_en),
    .wait_exec(wait_exec), .start(start), .auto_clr(auto_clr),
    .clock_val(clock_val), .en_eff(en_eff));

  utb_gap_timer #(.GAP_BASE(GAP_BASE)) u_gap (
    .clk(clk), .rst(rst), .gap_req(gap_req), .gap_sel(gap_sel),
    .pre_tick(pre_tick), .gap_done(gap_done), .gap_busy(gap_busy));
endmodule

// File: rtl/utb_checker.sv
module utb_checker #(
  parameter int unsigned CLK_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CLK_W-1:0] clock_val,
  input logic             rate_tick,
  input logic             gap_done,
  input logic             gap_busy,
  input logic             start,
  input logic             auto_clr,
  input logic             en_eff
);
  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    rate_tick |=> !rate_tick);

  p_gap_single_r8: assert property (@(posedge clk) disable iff (rst)
    gap_done |=> !gap_done);

  p_gap_from_busy_r8: assert property (@(posedge clk) disable iff (rst)
    gap_done |-> $past(gap_busy));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (start && auto_clr) |=> (clock_val == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!(start && auto_clr) && !(rate_tick && en_eff)) |=> $stable(clock_val));

  // Increment by one, wrapping at all ones (R7).
  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (!(start && auto_clr) && rate_tick && en_eff) |=>
      (clock_val == CLK_W'($past(clock_val) + 1'b1)));
endmodule

bind usec_timebase utb_checker #(.CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .clock_val(clock_val), .rate_tick(rate_tick),
  .gap_done(gap_done), .gap_busy(gap_busy), .start(start),
  .auto_clr(auto_clr), .en_eff(en_eff));

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] freq_sel = 2'b00, rate_sel = 2'b00, gap_sel = 2'b00;
  logic count_en = 1'b0, wait_exec = 1'b0, start = 1'b0, auto_clr = 1'b0;
  logic gap_req = 1'b0;
  logic [15:0] clock_val;
  logic [3:0]  clock_w4;
  logic rate_tick, gap_done, rate_tick_w4, gap_done_w4;

  int checks = 0;
  int errors = 0;
  bit wait_model = 1'b0;

  always #2.5 clk = ~clk;

  usec_timebase i_usec_timebase (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .rate_sel(rate_sel),
    .count_en(count_en), .wait_exec(wait_exec), .start(start),
    .auto_clr(auto_clr), .gap_req(gap_req), .gap_sel(gap_sel),
    .clock_val(clock_val), .rate_tick(rate_tick), .gap_done(gap_done));

  usec_timebase #(.CLK_W(4)) i_usec_timebase_w4 (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .rate_sel(rate_sel),
    .count_en(count_en), .wait_exec(wait_exec), .start(start),
    .auto_clr(auto_clr), .gap_req(gap_req), .gap_sel(gap_sel),
    .clock_val(clock_w4), .rate_tick(rate_tick_w4), .gap_done(gap_done_w4));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (rate_tick) break;
    end
  endtask

  task automatic period(output int p);
    wait_tick();
    p = 0;
    for (int i = 0; i < 2000; i++) begin
      step();
      p++;
      if (rate_tick) break;
    end
  endtask

  // R1 / R2: tick spacing for a frequency and rate code
  task automatic t_period(input logic [1:0] f, input logic [1:0] r);
    int p, exp, lens[4];
    lens = '{1, 4, 8, 32};
    freq_sel = f;
    rate_sel = r;
    period(p);
    period(p);
    period(p);
    exp = (12 + 4 * int'(f)) * lens[r];
    chk(p == exp, (r == 2'b00) ? "R1 prescale period" : "R2 rate period", p, exp);
  endtask

  // R3: tick width is one clock
  task automatic t_tick_width();
    int width = 0;
    freq_sel = 2'b00;
    rate_sel = 2'b01;
    wait_tick();
    while (rate_tick && width < 10) begin
      width++;
      step();
    end
    chk(width == 1, "R3 tick width", width, 1);
  endtask

  // R4 / R5 / R7: per-clock model of both counters over a window
  task automatic watch(input int cycles, input string req, output int moved);
    logic [15:0] prev;
    logic [3:0]  prev4;
    bit ptick, en, ok = 1'b1, wrapped = 1'b0;
    int bad_act = 0, bad_exp = 0;
    logic [15:0] start_val;
    step();
    prev = clock_val;
    prev4 = clock_w4;
    ptick = rate_tick;
    start_val = clock_val;
    en = count_en | wait_model;
    for (int i = 0; i < cycles; i++) begin
      logic [15:0] e;
      logic [3:0]  e4;
      step();
      e  = prev + 16'((ptick && en) ? 1 : 0);
      e4 = prev4 + 4'((ptick && en) ? 1 : 0);
      if (clock_val != e || clock_w4 != e4) begin
        if (ok) begin
          bad_act = int'(clock_val);
          bad_exp = int'(e);
        end
        ok = 1'b0;
      end
      if (prev4 == 4'hF && clock_w4 == 4'h0) wrapped = 1'b1;
      prev = clock_val;
      prev4 = clock_w4;
      ptick = rate_tick;
    end
    moved = int'(clock_val - start_val);
    chk(ok, req, bad_act, bad_exp);
    if (en && cycles > 300) chk(wrapped, "R7 narrow counter wrap", int'(wrapped), 1);
  endtask

  task automatic t_enable();
    int moved;
    freq_sel = 2'b00;
    rate_sel = 2'b00;
    count_en = 1'b0;
    watch(120, "R4 hold while disabled", moved);
    chk(moved == 0, "R4 no count while disabled", moved, 0);
    count_en = 1'b1;
    watch(400, "R4 count while enabled", moved);
    chk(moved >= 30, "R4 count advanced", moved, 33);
    count_en = 1'b0;
    watch(60, "R4 hold after disable", moved);
    chk(moved == 0, "R4 stopped", moved, 0);
  endtask

  // R5: wait flag keeps counting with count_en low
  task automatic t_wait();
    int moved;
    count_en = 1'b0;
    wait_exec = 1'b1;
    step();
    wait_exec = 1'b0;
    wait_model = 1'b1;
    watch(200, "R5 counting after wait", moved);
    chk(moved >= 15, "R5 wait enables count", moved, 16);
  endtask

  // R6: start with and without auto clear
  task automatic t_start();
    logic [15:0] v;
    bit t;
    count_en = 1'b1;
    wait_tick();
    step();
    // Clear on the same clock as a pending increment.
    for (int i = 0; i < 2000; i++) begin
      if (rate_tick) break;
      step();
    end
    start = 1'b1;
    auto_clr = 1'b1;
    step();
    start = 1'b0;
    auto_clr = 1'b0;
    chk(clock_val == 16'd0, "R6 clear beats increment", int'(clock_val), 0);
    watch(100, "R6 counting resumes", v);
    v = clock_val;
    t = rate_tick;
    start = 1'b1;
    auto_clr = 1'b0;
    step();
    start = 1'b0;
    chk(clock_val == v + 16'(t), "R6 start without clear", int'(clock_val), int'(v + 16'(t)));
  endtask

  // R8: exact gap length in pre-ticks, rate code 00
  task automatic t_gap_exact(input logic [1:0] gs, input bit restart);
    int n = 0, exp;
    bit seen = 1'b0, with_tick = 1'b0;
    freq_sel = 2'b01;
    rate_sel = 2'b00;
    gap_sel = gs;
    exp = 4 << gs;
    gap_req = 1'b1;
    step();
    gap_req = 1'b0;
    if (restart) begin
      for (int i = 0; i < 40; i++) step();
      gap_req = 1'b1;
      step();
      gap_req = 1'b0;
    end
    chk(!gap_done, "R8 no immediate done", int'(gap_done), 0);
    for (int i = 0; i < 2000; i++) begin
      step();
      if (rate_tick) n++;
      if (gap_done) begin
        seen = 1'b1;
        with_tick = rate_tick;
        break;
      end
    end
    chk(seen && n == exp && with_tick, restart ? "R8 gap after restart" : "R8 gap length", n, exp);
    step();
    chk(!gap_done, "R8 done single clock", int'(gap_done), 0);
  endtask

  // R8: gap ignores the rate code
  task automatic t_gap_rate();
    int lat = 0, per;
    bit seen = 1'b0;
    freq_sel = 2'b11;
    rate_sel = 2'b11;
    gap_sel = 2'b01;
    per = 24;
    gap_req = 1'b1;
    step();
    gap_req = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      step();
      lat++;
      if (gap_done) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen && lat > 7 * per && lat <= 8 * per, "R8 gap independent of rate", lat, 8 * per);
  endtask

  // R9: reset state and wait flag cleared
  task automatic t_reset();
    int moved;
    rst = 1'b1;
    count_en = 1'b0;
    for (int i = 0; i < 4; i++) step();
    rst = 1'b0;
    wait_model = 1'b0;
    chk(clock_val == 0 && !rate_tick && !gap_done, "R9 reset outputs", int'(clock_val), 0);
    watch(150, "R9 wait flag cleared", moved);
    chk(moved == 0 && clock_val == 0, "R9 idle after reset", int'(clock_val), 0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) step();
    rst = 1'b0;
    chk(clock_val == 0 && !rate_tick && !gap_done, "R9 initial reset", int'(clock_val), 0);
    for (int f = 0; f < 4; f++) t_period(2'(f), 2'b00);
    for (int r = 1; r < 4; r++) t_period(2'b00, 2'(r));
    t_period(2'b10, 2'b01);
    t_tick_width();
    t_enable();
    t_wait();
    t_start();
    t_gap_exact(2'b00, 1'b0);
    t_gap_exact(2'b11, 1'b0);
    t_gap_exact(2'b10, 1'b1);
    t_gap_rate();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule